// File: doc/BRIEF.md
# Fixed-Point PID Motor Controller

This block closes a position loop for a motor. On every clock edge it takes a signed setpoint and a signed measured position, forms the error, and updates a registered signed motor command. That command is the sum of a proportional, an integral and a derivative term. Only integer multiply, arithmetic shift and add are used. Each gain arrives as a signed mantissa with a small right-shift exponent, so all fractional scaling lives in the constants and no divider is needed.

The integral path is bounded in two ways. The amount added on each edge is limited to a programmable magnitude, and the accumulator itself is limited to a second programmable magnitude, so a wheel held away from its target cannot wind the integral up. The derivative is refreshed only once every N edges, against the error sampled N edges earlier. Between refreshes the difference is held, which smooths the output when the position feedback is coarse. Every sum and product is formed at full width and then saturated, so no result ever wraps.

Top module: `pid_motor_core`

## Requirements
- R1: While `rst_n` is low the accumulator, stored previous error, held difference, decimation counter and `cmd` are all zero, and `cmd` reads 0. Reset is asserted asynchronously and released on the second rising clock edge after `rst_n` rises. The first edge after that release is the first functional edge.
- R2: The error is `setpoint - position`, computed at full precision and saturated to the range [-32768, 32767].
- R3: Each term is (mantissa × signal) arithmetically right-shifted by the exponent, which rounds toward minus infinity, then saturated to 16 signed bits. Mantissas are two's complement. Exponents are unsigned, 0 to 15.
- R4: `cmd` is the full-precision sum of the three saturated terms, saturated to [-32768, 32767].
- R5: Before the error is added to the accumulator, it is clamped to [-`inc_cap`, +`inc_cap`]. `inc_cap` is a 15-bit unsigned magnitude.
- R6: After the addition the accumulator is clamped to [-`acc_cap`, +`acc_cap`]. `acc_cap` is a 15-bit unsigned magnitude. The integral term on an edge uses the accumulator value that edge produces.
- R7: A counter starts at 0 and advances on each functional edge, running from 0 to N-1. On the edge where it stands at N-1, the held difference becomes the saturated (error − stored error), the stored error takes the current error, and the counter returns to 0. On all other edges the difference is held. The derivative term uses the difference held before the edge.
- R8: `cmd` is registered. It changes only at a rising edge and reflects the inputs present just before that edge.
- R9: When all three mantissas are zero before an edge, `cmd` is 0 after it, whatever the error, exponents or state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setpoint | input | 16 | Signed target position |
| position | input | 16 | Signed measured position |
| kp_man | input | 16 | Proportional gain mantissa, signed |
| kp_exp | input | 4 | Proportional gain right shift |
| ki_man | input | 16 | Integral gain mantissa, signed |
| ki_exp | input | 4 | Integral gain right shift |
| kd_man | input | 16 | Derivative gain mantissa, signed |
| kd_exp | input | 4 | Derivative gain right shift |
| inc_cap | input | 15 | Largest magnitude added to the accumulator per edge |
| acc_cap | input | 15 | Largest accumulator magnitude |
| cmd | output | 16 | Signed registered motor command |

## Verification
On every cycle the assertions check four things: the accumulator stays inside the previous edge's accumulator limit, it moves by no more than the increment limit while that accumulator limit is steady, the held difference changes only on the counter's wrap edge, and all-zero mantissas give a zero command. Exact values can only be shown by the bench's scenarios. These include shift rounding on negative products, saturation of the error, the products and the final sum, the integral climbing against its step and magnitude limits and then being cut back when the limit shrinks, the phase of the derivative refresh against the edge count from reset, and the clearing of all state by a mid-run reset.

// File: rtl/pid_pkg.sv
package pid_pkg;

  localparam int PID_DW    = 16;
  localparam int PID_EW    = 4;
  localparam int PID_DECIM = 4096;

  // Saturate a wide signed value to a dw-bit signed range.
  function automatic logic signed [63:0] sat_s(input logic signed [63:0] v,
                                               input int unsigned        dw);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (dw - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi)      sat_s = hi;
    else if (v < lo) sat_s = lo;
    else             sat_s = v;
  endfunction

  // Clamp a wide signed value to [-m, +m], m >= 0.
  function automatic logic signed [63:0] clamp_sym(input logic signed [63:0] v,
                                                   input logic signed [63:0] m);
    if (v > m)       clamp_sym = m;
    else if (v < -m) clamp_sym = -m;
    else             clamp_sym = v;
  endfunction

endpackage

// File: rtl/pid_scale.sv
module pid_scale #(
  parameter int DW = pid_pkg::PID_DW,
  parameter int EW = pid_pkg::PID_EW
) (
  input  logic signed [DW-1:0] man,
  input  logic        [EW-1:0] shf,
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] y
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shd;

  always_comb begin
    prod = PW'(man) * PW'(x);
    shd  = prod >>> shf;
    y    = DW'(pid_pkg::sat_s(64'(shd), DW));
  end
endmodule

// File: rtl/pid_integ.sv
module pid_integ #(
  parameter int DW = pid_pkg::PID_DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] err,
  input  logic        [DW-2:0] inc_cap,
  input  logic        [DW-2:0] acc_cap,
  output logic signed [DW-1:0] acc_nxt
);
  logic signed [DW-1:0] acc_q;
  logic signed [DW-1:0] acc_d;
  logic signed [63:0]   inc_w;
  logic signed [63:0]   sum_w;

  always_comb begin
    inc_w = pid_pkg::clamp_sym(64'(err), $signed(64'(inc_cap)));
    sum_w = pid_pkg::sat_s(64'(acc_q) + inc_w, DW);
    acc_d = DW'(pid_pkg::clamp_sym(sum_w, $signed(64'(acc_cap))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_nxt = acc_d;
endmodule

// File: rtl/pid_deriv.sv
module pid_deriv #(
  parameter int DW = pid_pkg::PID_DW,
  parameter int N  = pid_pkg::PID_DECIM,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] err,
  output logic signed [DW-1:0] diff
);
  logic [CW-1:0]        cnt_q;
  logic [CW-1:0]        cnt_d;
  logic signed [DW-1:0] prev_q;
  logic signed [DW-1:0] prev_d;
  logic signed [DW-1:0] diff_q;
  logic signed [DW-1:0] diff_d;
  logic                 wrap;

  always_comb begin
    wrap   = (cnt_q == CW'(N - 1));
    cnt_d  = wrap ? '0 : cnt_q + CW'(1);
    prev_d = wrap ? err : prev_q;
    diff_d = wrap ? DW'(pid_pkg::sat_s(64'(err) - 64'(prev_q), DW)) : diff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= '0;
      diff_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= prev_d;
      diff_q <= diff_d;
    end
  end

  assign diff = diff_q;
endmodule

// File: rtl/pid_motor_core.sv
module pid_motor_core #(
  parameter int DW = pid_pkg::PID_DW,
  parameter int EW = pid_pkg::PID_EW,
  parameter int N  = pid_pkg::PID_DECIM
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] setpoint,
  input  logic signed [DW-1:0] position,
  input  logic signed [DW-1:0] kp_man,
  input  logic        [EW-1:0] kp_exp,
  input  logic signed [DW-1:0] ki_man,
  input  logic        [EW-1:0] ki_exp,
  input  logic signed [DW-1:0] kd_man,
  input  logic        [EW-1:0] kd_exp,
  input  logic        [DW-2:0] inc_cap,
  input  logic        [DW-2:0] acc_cap,
  output logic signed [DW-1:0] cmd
);
  localparam int NT = 3;

  logic                 rst_meta;
  logic                 rst_sync_n;
  logic signed [DW-1:0] err;
  logic signed [DW-1:0] acc_nxt;
  logic signed [DW-1:0] diff;
  logic signed [DW-1:0] t_man [NT];
  logic        [EW-1:0] t_exp [NT];
  logic signed [DW-1:0] t_in  [NT];
  logic signed [DW-1:0] t_out [NT];
  logic signed [63:0]   sum_w;
  logic signed [DW-1:0] cmd_d;
  logic signed [DW-1:0] cmd_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    err = DW'(pid_pkg::sat_s(64'(setpoint) - 64'(position), DW));
  end

  pid_integ #(.DW(DW)) u_integ (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .err     (err),
    .inc_cap (inc_cap),
    .acc_cap (acc_cap),
    .acc_nxt (acc_nxt)
  );

  pid_deriv #(.DW(DW), .N(N)) u_deriv (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .err   (err),
    .diff  (diff)
  );

  always_comb begin
    t_man[0] = kp_man;  t_exp[0] = kp_exp;  t_in[0] = err;
    t_man[1] = ki_man;  t_exp[1] = ki_exp;  t_in[1] = acc_nxt;
    t_man[2] = kd_man;  t_exp[2] = kd_exp;  t_in[2] = diff;
  end

  for (genvar g = 0; g < NT; g++) begin : g_term
    pid_scale #(.DW(DW), .EW(EW)) u_scale (
      .man (t_man[g]),
      .shf (t_exp[g]),
      .x   (t_in[g]),
      .y   (t_out[g])
    );
  end

  always_comb begin
    sum_w = 64'(t_out[0]) + 64'(t_out[1]) + 64'(t_out[2]);
    cmd_d = DW'(pid_pkg::sat_s(sum_w, DW));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cmd_q <= '0;
    else             cmd_q <= cmd_d;
  end

  assign cmd = cmd_q;
endmodule

// File: rtl/pid_motor_core_chk.sv
module pid_motor_core_chk #(
  parameter int DW = 16,
  parameter int N  = 4096,
  parameter int CW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [DW-1:0] kp_man,
  input logic signed [DW-1:0] ki_man,
  input logic signed [DW-1:0] kd_man,
  input logic        [DW-2:0] inc_cap,
  input logic        [DW-2:0] acc_cap,
  input logic signed [DW-1:0] acc,
  input logic signed [DW-1:0] diff,
  input logic        [CW-1:0] cnt,
  input logic signed [DW-1:0] cmd
);
  function automatic logic [DW:0] mag(input logic signed [DW:0] v);
    mag = (v < 0) ? $unsigned(-v) : $unsigned(v);
  endfunction

  AST_INTEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (mag((DW+1)'(acc)) <= (DW+1)'($past(acc_cap)))); // R6

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(acc_cap) |=> (mag((DW+1)'(acc) - (DW+1)'($past(acc))) <= (DW+1)'($past(inc_cap)))); // R5

  AST_DERIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != CW'(N - 1)) |=> $stable(diff)); // R7

  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (kp_man == '0 && ki_man == '0 && kd_man == '0) |=> (cmd == '0)); // R9
endmodule

bind pid_motor_core pid_motor_core_chk #(
  .DW (DW),
  .N  (N),
  .CW ((N > 1) ? $clog2(N) : 1)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .kp_man  (kp_man),
  .ki_man  (ki_man),
  .kd_man  (kd_man),
  .inc_cap (inc_cap),
  .acc_cap (acc_cap),
  .acc     (u_integ.acc_q),
  .diff    (u_deriv.diff_q),
  .cnt     (u_deriv.cnt_q),
  .cmd     (cmd)
);

// File: tb/test_pid_motor_core.sv
`timescale 1ns/1ps
module test_pid_motor_core;
  localparam int DW = 16;
  localparam int EW = 4;
  localparam int N  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n;
  logic signed [DW-1:0] setpoint, position;
  logic signed [DW-1:0] kp_man, ki_man, kd_man;
  logic        [EW-1:0] kp_exp, ki_exp, kd_exp;
  logic        [DW-2:0] inc_cap, acc_cap;
  logic signed [DW-1:0] cmd;

  pid_motor_core #(.DW(DW), .EW(EW), .N(N)) i_pid_motor_core (
    .clk(clk), .rst_n(rst_n), .setpoint(setpoint), .position(position),
    .kp_man(kp_man), .kp_exp(kp_exp), .ki_man(ki_man), .ki_exp(ki_exp),
    .kd_man(kd_man), .kd_exp(kd_exp), .inc_cap(inc_cap), .acc_cap(acc_cap),
    .cmd(cmd)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // gain/cap settings applied by the driver
  longint g_kp = 0, g_ki = 0, g_kd = 0;
  int     g_kpe = 0, g_kie = 0, g_kde = 0;
  longint g_ic = 0, g_ac = 0;

  // reference state
  longint m_acc = 0, m_prev = 0, m_diff = 0;
  int     m_cnt = 0;

  int    q_exp[$];
  string q_tag[$];

  function automatic longint sat(input longint v, input longint lo, input longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint s16(input longint v);
    return sat(v, -32768, 32767);
  endfunction

  function automatic longint scl(input longint m, input int sh, input longint x);
    longint p;
    p = (m * x) >>> sh;
    return s16(p);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: cmd=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input longint sp, input longint pos, input string tag);
    longint e, inc, an, ex;
    @(negedge clk);
    setpoint = DW'(sp);   position = DW'(pos);
    kp_man = DW'(g_kp);   kp_exp = EW'(g_kpe);
    ki_man = DW'(g_ki);   ki_exp = EW'(g_kie);
    kd_man = DW'(g_kd);   kd_exp = EW'(g_kde);
    inc_cap = (DW-1)'(g_ic); acc_cap = (DW-1)'(g_ac);
    e   = s16(sp - pos);
    inc = sat(e, -g_ic, g_ic);
    an  = sat(s16(m_acc + inc), -g_ac, g_ac);
    ex  = s16(scl(g_kp, g_kpe, e) + scl(g_ki, g_kie, an) + scl(g_kd, g_kde, m_diff));
    m_acc = an;
    if (m_cnt == N - 1) begin
      m_diff = s16(e - m_prev);
      m_prev = e;
      m_cnt  = 0;
    end else begin
      m_cnt++;
    end
    @(posedge clk);
    q_exp.push_back(int'(ex));
    q_tag.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    m_acc = 0; m_prev = 0; m_diff = 0; m_cnt = 0;
    repeat (2) @(negedge clk);
    check("R1 reset value", longint'(cmd), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  // monitor: compare each result one edge after it was driven (R8)
  initial begin
    forever begin
      @(negedge clk);
      if (q_exp.size() > 0) begin
        int    ev;
        string tg;
        ev = q_exp.pop_front();
        tg = q_tag.pop_front();
        check(tg, longint'(cmd), longint'(ev));
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    setpoint = '0; position = '0;
    kp_man = '0; ki_man = '0; kd_man = '0;
    kp_exp = '0; ki_exp = '0; kd_exp = '0;
    inc_cap = '0; acc_cap = '0;
    do_reset();

    // R3 / R8: proportional only, unity and fractional gains
    g_kp = 256; g_kpe = 8;
    step(1000, 900, "R3 R8 unity gain");
    step(-500, 200, "R3 negative error");
    g_kp = 3; g_kpe = 1;
    step(7, 0, "R3 shift positive");
    step(0, 7, "R3 shift floor negative");
    // R2: error saturation
    g_kp = 1; g_kpe = 0;
    step(32767, -32768, "R2 error high clamp");
    step(-32768, 32767, "R2 error low clamp");
    // R3: product saturation and large shift
    g_kp = 32767; g_kpe = 0;
    step(1000, 0, "R3 product clamp");
    g_kpe = 15;
    step(1000, 0, "R3 shift fifteen");
    g_kp = -32768; g_kpe = 0;
    step(1000, 0, "R3 negative mantissa clamp");

    // R9: zero mantissas
    g_kp = 0; g_kpe = 5; g_kie = 3; g_kde = 9;
    for (int i = 0; i < 4; i++) step(20000, -20000 + i, "R9 zero gains");

    // R5 / R6: integral step and magnitude limits
    g_ki = 1; g_kie = 0; g_kde = 0; g_ic = 10; g_ac = 35;
    for (int i = 0; i < 6; i++) step(100, 0, "R5 R6 integral rise");
    for (int i = 0; i < 3; i++) step(0, 3, "R5 small negative step");
    for (int i = 0; i < 10; i++) step(-1000, 0, "R5 R6 integral fall");
    g_ac = 20;
    step(0, 0, "R6 shrunk limit");
    g_ic = 0;
    step(5000, 0, "R5 zero increment");

    // R4: sum saturation
    g_kp = 32767; g_ki = 32767; g_ic = 32767; g_ac = 32767;
    for (int i = 0; i < 3; i++) step(1000, 0, "R4 sum high clamp");
    for (int i = 0; i < 3; i++) step(-1000, 0, "R4 sum mixed");
    g_ki = -2; g_kp = 1; g_ac = 500;
    for (int i = 0; i < 4; i++) step(-2000, 0, "R4 opposing terms");

    // R1: mid-run reset clears accumulated state
    do_reset();
    g_kp = 0; g_ki = 1; g_kie = 0; g_ic = 100; g_ac = 1000;
    step(5, 0, "R1 accumulator cleared");
    step(5, 0, "R1 accumulator restart");

    // R7: decimated derivative
    g_ki = 0; g_kd = 1; g_kde = 0;
    for (int i = 0; i < 40; i++) step(longint'(((i / 3) % 5) * 300 - 600), 0, "R7 derivative hold");
    g_kd = -2;
    for (int i = 0; i < 20; i++) step(longint'(i * 1500), 0, "R7 derivative negative gain");

    @(negedge clk);
    @(negedge clk);
    check("R8 queue drained", longint'(q_exp.size()), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule